// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupts

This block gives software control of a bank of general-purpose pins through a small memory-mapped register set with 16-bit data. Each pin can be made an output or an input. Output levels are changed through a pair of write ports: one sets bits and one clears them, so that no read-modify-write is needed. Every input is passed through a two-stage synchroniser, and its sampled level can be read back.

Each pin can raise an interrupt. In level mode the interrupt is raised while the pin sits at a chosen polarity. In edge mode the rising and falling edges have their own enables, and the pin can fire on both. A mask (1 blocks) and an enable (1 passes) gate every source before it is latched into a status register. Software clears that register by writing ones. The OR of the gated status bits drives a single interrupt line.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Byte offsets are: direction 0x00, level select 0x04, polarity 0x08, rise enable 0x0C, fall enable 0x10, input level 0x14, output set 0x18, output clear 0x1C, output latch 0x20, mask 0x28, enable 0x2C, status 0x30, status clear 0x34. Writes take effect on the clock edge that samples `bus_wr`. Reads are combinational from `bus_addr`.
- R2: The direction register drives `pin_oe` bit for bit. A 1 makes the pin an output and a 0 makes it an input. It resets to zero and reads back as written.
- R3: A write to the set port ORs the data into the output latch. A write to the clear port removes the written ones. Zero bits leave their outputs alone. `pin_out` and reads of offset 0x20 show the latch, which resets to zero.
- R4: Reads of offset 0x14 return `pin_in` after a two-flop synchroniser. A change that is set up before one clock edge is visible after the second edge and not after the first.
- R5: When a pin's level-select bit is 1, the pin is level-sensitive. Polarity 1 is active-high and 0 is active-low. Its status bit is set again on every cycle while the pin is active, so a clear has no lasting effect until the pin goes inactive.
- R6: When a pin's level-select bit is 0, its rising enable and falling enable act independently, and with both set the pin fires on either edge. A status bit that an edge has set stays set until it is cleared.
- R7: A source reaches the status register only while its mask bit is 0 and its enable bit is 1. The mask resets to all ones and the enable resets to all zeros.
- R8: Writing ones to offset 0x34 clears those status bits. If a new event lands in the same cycle as the clear, the event wins.
- R9: Offset 0x30 reads the pending bits that are currently unmasked and enabled. `irq` is the OR of those bits.
- R10: Unused offsets read as zero and ignore writes. Writes to the input-level and status offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW (6) | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one write per cycle high |
| bus_wdata | input | NPIN (16) | Write data |
| bus_rdata | output | NPIN (16) | Read data for `bus_addr` |
| pin_in | input | NPIN (16) | Asynchronous pin levels |
| pin_out | output | NPIN (16) | Output latch |
| pin_oe | output | NPIN (16) | Output enable per pin (the direction register) |
| irq | output | 1 | Combined interrupt |

## Verification
The detection logic is tried against a table of pin transitions crossed with trigger settings. The table covers rising only, falling only, both edges, no edge enable, and both polarities of level mode, each in an active and an inactive direction. The results separate correct edge polarity from swapped polarity and edge detection from level detection. Directed cases cover the points where behaviours meet: a clear issued against an active level, a clear landing in the same cycle as a new edge, mask and enable disagreeing, and the latency of the synchroniser counted edge by edge. Set and clear writes use overlapping patterns, so that untouched bits show whether the zeros in a write were honoured.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NPIN = 16,
  parameter int AW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [NPIN-1:0] bus_wdata,
  output logic [NPIN-1:0] bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic            irq
);

  localparam logic [AW-1:0] A_DIR  = AW'(6'h00);
  localparam logic [AW-1:0] A_LSEL = AW'(6'h04);
  localparam logic [AW-1:0] A_POL  = AW'(6'h08);
  localparam logic [AW-1:0] A_RISE = AW'(6'h0C);
  localparam logic [AW-1:0] A_FALL = AW'(6'h10);
  localparam logic [AW-1:0] A_IN   = AW'(6'h14);
  localparam logic [AW-1:0] A_SET  = AW'(6'h18);
  localparam logic [AW-1:0] A_CLR  = AW'(6'h1C);
  localparam logic [AW-1:0] A_OUT  = AW'(6'h20);
  localparam logic [AW-1:0] A_MSK  = AW'(6'h28);
  localparam logic [AW-1:0] A_ENA  = AW'(6'h2C);
  localparam logic [AW-1:0] A_STAT = AW'(6'h30);
  localparam logic [AW-1:0] A_ACK  = AW'(6'h34);

  logic [NPIN-1:0] dir_q, lsel_q, pol_q, rise_q, fall_q;
  logic [NPIN-1:0] out_q, msk_q, ena_q, stat_q;
  logic [NPIN-1:0] sync1_q, sync2_q, prev_q;

  logic [NPIN-1:0] lvl_hit, edge_hit, event_v, gated, ack_v, pend;

  assign lvl_hit  = lsel_q & ~(sync2_q ^ pol_q);
  assign edge_hit = ~lsel_q & ((rise_q & sync2_q & ~prev_q) | (fall_q & ~sync2_q & prev_q));
  assign event_v  = lvl_hit | edge_hit;
  assign gated    = event_v & ~msk_q & ena_q;
  assign ack_v    = (bus_wr && bus_addr == A_ACK) ? bus_wdata : '0;
  assign pend     = stat_q & ~msk_q & ena_q;

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = |pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~ack_v) | gated;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      lsel_q <= '0;
      pol_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      out_q  <= '0;
      msk_q  <= '1;
      ena_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_DIR:   dir_q  <= bus_wdata;
        A_LSEL:  lsel_q <= bus_wdata;
        A_POL:   pol_q  <= bus_wdata;
        A_RISE:  rise_q <= bus_wdata;
        A_FALL:  fall_q <= bus_wdata;
        A_SET:   out_q  <= out_q | bus_wdata;
        A_CLR:   out_q  <= out_q & ~bus_wdata;
        A_MSK:   msk_q  <= bus_wdata;
        A_ENA:   ena_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      A_DIR:   bus_rdata = dir_q;
      A_LSEL:  bus_rdata = lsel_q;
      A_POL:   bus_rdata = pol_q;
      A_RISE:  bus_rdata = rise_q;
      A_FALL:  bus_rdata = fall_q;
      A_IN:    bus_rdata = sync2_q;
      A_OUT:   bus_rdata = out_q;
      A_MSK:   bus_rdata = msk_q;
      A_ENA:   bus_rdata = ena_q;
      A_STAT:  bus_rdata = pend;
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int NPIN = 16,
  parameter int AW   = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_wr,
  input logic [NPIN-1:0] bus_wdata,
  input logic [NPIN-1:0] pin_out,
  input logic [NPIN-1:0] pin_oe,
  input logic            irq,
  input logic [NPIN-1:0] msk_q,
  input logic [NPIN-1:0] ena_q,
  input logic [NPIN-1:0] stat_q
);
  localparam logic [AW-1:0] C_DIR = AW'(6'h00);
  localparam logic [AW-1:0] C_SET = AW'(6'h18);
  localparam logic [AW-1:0] C_CLR = AW'(6'h1C);
  localparam logic [AW-1:0] C_ACK = AW'(6'h34);

  AST_SET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == C_SET) |=> pin_out == ($past(pin_out) | $past(bus_wdata))); // R3
  AST_CLR_ANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == C_CLR) |=> pin_out == ($past(pin_out) & ~$past(bus_wdata))); // R3
  AST_OE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == C_DIR) |=> $stable(pin_oe)); // R2
  AST_GATED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&(msk_q | ~ena_q)) |-> !irq); // R7
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == C_ACK) |=> (($past(stat_q) & ~stat_q) == '0)); // R6
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPIN(NPIN), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .msk_q(msk_q), .ena_q(ena_q), .stat_q(stat_q)
);

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NPIN = 16;
  localparam int AW = 6;

  // {lvl_sel, pol, rise, fall, start, end, expected}
  localparam int NV = 11;
  localparam logic [6:0] VEC [NV] = '{
    7'b0010011, 7'b0010100, 7'b0001101, 7'b0001010,
    7'b0011011, 7'b0011101, 7'b0000010,
    7'b1100011, 7'b1100000, 7'b1000101, 7'b1000110
  };

  logic clk = 0, rst_n = 0, bus_wr = 0, irq;
  logic [AW-1:0] bus_addr = '0;
  logic [NPIN-1:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
  int checks = 0, fails = 0;
  logic done = 0;

  gpio_irq_ctrl #(.NPIN(NPIN), .AW(AW)) u_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [NPIN-1:0] got, input logic [NPIN-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NPIN-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [NPIN-1:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [NPIN-1:0] r;
    idle(2);
    rst_n = 1;
    idle(1);
    // Reset state
    chk("R2 reset oe", pin_oe, '0);
    chk("R3 reset out", pin_out, '0);
    chk("R9 reset irq", {15'b0, irq}, '0);
    rd(6'h28, r); chk("R7 reset mask", r, 16'hFFFF);
    rd(6'h2C, r); chk("R7 reset enable", r, 16'h0000);
    rd(6'h30, r); chk("R9 reset status", r, 16'h0000);

    // Direction and output latch
    wr(6'h00, 16'hA5C3);
    chk("R2 oe follows direction", pin_oe, 16'hA5C3);
    rd(6'h00, r); chk("R2 direction readback", r, 16'hA5C3);
    wr(6'h18, 16'h00FF);
    wr(6'h18, 16'h0F0F);
    chk("R3 set ors", pin_out, 16'h0FFF);
    wr(6'h1C, 16'h0330);
    chk("R3 clear removes ones", pin_out, 16'h0CCF);
    rd(6'h20, r); chk("R3 latch readback", r, 16'h0CCF);

    // Unused and read-only offsets (R10)
    wr(6'h24, 16'hFFFF);
    rd(6'h24, r); chk("R10 unused reads zero", r, '0);
    rd(6'h38, r); chk("R10 unused high reads zero", r, '0);
    chk("R10 unused write leaves outputs", pin_out, 16'h0CCF);
    wr(6'h14, 16'hFFFF);
    rd(6'h14, r); chk("R10 input offset not writable", r, '0);
    wr(6'h30, 16'hFFFF);
    rd(6'h30, r); chk("R10 status offset not writable", r, '0);

    // Synchroniser latency R4
    @(negedge clk); pin_in = 16'h1234;
    @(posedge clk); @(negedge clk);
    rd(6'h14, r); chk("R4 not visible after one edge", r, 16'h0000);
    @(posedge clk); @(negedge clk);
    rd(6'h14, r); chk("R4 visible after two edges", r, 16'h1234);

    // Table of trigger configurations (R5, R6, R1 offsets)
    wr(6'h28, 16'h0000);
    for (int i = 0; i < NV; i++) begin
      int p;
      logic [NPIN-1:0] b;
      p = (i * 3 + 1) % NPIN;
      b = NPIN'(1) << p;
      wr(6'h2C, 16'h0000);
      pin_in = VEC[i][2] ? b : '0;
      idle(4);
      wr(6'h04, VEC[i][6] ? b : '0);
      wr(6'h08, VEC[i][5] ? b : '0);
      wr(6'h0C, VEC[i][4] ? b : '0);
      wr(6'h10, VEC[i][3] ? b : '0);
      wr(6'h34, 16'hFFFF);
      wr(6'h2C, b);
      pin_in = VEC[i][1] ? b : '0;
      idle(5);
      rd(6'h30, r);
      chk($sformatf("R6/R5 vector %0d status", i), r, VEC[i][0] ? b : '0);
      chk($sformatf("R9 vector %0d irq", i), {15'b0, irq}, {15'b0, VEC[i][0]});
    end

    // R5: level-high active on pin 3, clear has no lasting effect
    wr(6'h2C, 16'h0000);
    wr(6'h04, 16'h0008); wr(6'h08, 16'h0008);
    wr(6'h0C, 16'h0000); wr(6'h10, 16'h0000);
    pin_in = 16'h0000; idle(4);
    wr(6'h34, 16'hFFFF);
    wr(6'h2C, 16'h0008);
    pin_in = 16'h0008; idle(4);
    wr(6'h34, 16'h0008);
    rd(6'h30, r); chk("R5 level re-sets after clear", r, 16'h0008);
    pin_in = 16'h0000; idle(4);
    wr(6'h34, 16'h0008);
    rd(6'h30, r); chk("R5 clear works once inactive", r, 16'h0000);

    // R6 sticky edge then R8 clear; R7 gating
    wr(6'h04, 16'h0000);
    wr(6'h0C, 16'h0008); wr(6'h10, 16'h0008);
    pin_in = 16'h0008; idle(6);
    rd(6'h30, r); chk("R6 edge status sticky", r, 16'h0008);
    wr(6'h34, 16'h0008);
    rd(6'h30, r); chk("R8 w1c clears", r, 16'h0000);

    // R8: new falling edge in the same cycle as a clear
    pin_in = 16'h0008; idle(2);
    wr(6'h34, 16'hFFFF);
    pin_in = 16'h0000;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_addr = 6'h34; bus_wdata = 16'h0008; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    rd(6'h30, r); chk("R8 event wins over clear", r, 16'h0008);
    wr(6'h34, 16'h0008);

    // R7: mask blocks even with enable
    wr(6'h28, 16'h0008);
    pin_in = 16'h0008; idle(5);
    wr(6'h28, 16'h0000);
    rd(6'h30, r); chk("R7 masked source not latched", r, 16'h0000);
    chk("R9 irq low when nothing pending", {15'b0, irq}, '0);
    // R9: pending bit hidden by mask but kept
    pin_in = 16'h0000; idle(5);
    wr(6'h28, 16'h0008);
    rd(6'h30, r); chk("R9 mask hides pending", r, 16'h0000);
    chk("R9 irq follows masked view", {15'b0, irq}, '0);
    wr(6'h28, 16'h0000);
    rd(6'h30, r); chk("R9 unmask shows pending", r, 16'h0008);
    chk("R9 irq raised", {15'b0, irq}, 16'h0001);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule